// File: doc/BRIEF.md
# Channel Command Status Responder

This block forms the status side of a control unit that serves several attached devices on a byte-wide channel. When the channel opens an initial selection, the block takes the device address, the command code, a parity-error flag for the command byte and an intervention-required flag. One cycle later it returns a status byte and an accept or reject decision. The decision depends on the class of the command, on status already pending for the addressed device or for another device, on an operation still in flight, and on whether a reset is running in the control unit.

Accepted commands that do not finish at once become the single operation in flight. When the data path signals completion, the block queues ending status for that device. Channel End and Device End are queued together or as two separate events, according to the command class. Queued status, together with asynchronous conditions posted by the device side, is offered to the channel one device at a time. Each offered byte is cleared when the channel acknowledges it.

Status byte bit positions, from bit 7 down to bit 0: Attention, Status Modifier, Control Unit End, Busy, Channel End, Device End, Unit Check, Unit Exception.

Top module: `chan_status_resp`

## Requirements
- R1: The reply (`rsp_valid`, `rsp_status`, `rsp_accept`) appears exactly one clock after `sel_valid` and lasts one cycle. After reset no reply and no offered status are present.
- R2: Data commands (codes 0x01, 0x02, 0x05, 0x06, 0x0D) and completion-reported commands (0x04, 0x0A, 0x12, 0xE4) are accepted with status 0x00 when nothing blocks them.
- R3: Immediate commands (0x0B, 0x0F, 0x1B) are accepted with status 0x08 (Channel End). When `done_valid` pulses, Device End (0x04) is queued for that device.
- R4: No-operation (0x03) is accepted with status 0x0C (Channel End and Device End) and leaves no operation in flight.
- R5: An undefined code, `sel_perr` or `sel_intv` gives status 0x02 (Unit Check alone) and a reject.
- R6: With status pending for the addressed device, any command other than Test I/O (0x00) is rejected with that pending byte OR 0x10 (Busy). The pending byte is kept.
- R7: Test I/O returns the addressed device's pending byte, or 0x00 if none, and is accepted. Only that device's pending status is cleared.
- R8: With status pending for another device and none for the addressed one, commands other than Test I/O are rejected with 0x50 (Busy and Status Modifier).
- R9: While an operation is in flight, selecting its own device gives 0x10 and selecting another device gives 0x50. Both are rejected.
- R10: On `done_valid`, a data command first queues 0x08. Device End 0x04 is queued only after the channel acknowledges that byte. A completion-reported command queues 0x0C at once.
- R11: While `rst_busy` is high, every selection is rejected with 0x50.
- R12: `stat_valid` offers the lowest-numbered device with nonzero pending status. `stat_ack` while offered clears that byte, and `post_valid` ORs `post_bits` into the pending byte of `post_dev`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_valid | input | 1 | Initial selection pulse |
| sel_dev | input | DEV_W | Addressed device |
| sel_cmd | input | 8 | Command code |
| sel_perr | input | 1 | Parity error on the command byte |
| sel_intv | input | 1 | Addressed device needs intervention |
| rst_busy | input | 1 | Reset processing in progress |
| done_valid | input | 1 | Operation in flight has completed |
| post_valid | input | 1 | Post asynchronous status |
| post_dev | input | DEV_W | Device for posted status |
| post_bits | input | 8 | Status bits to post |
| stat_ack | input | 1 | Channel takes the offered status |
| rsp_valid | output | 1 | Selection reply valid |
| rsp_status | output | 8 | Selection status byte |
| rsp_accept | output | 1 | Command accepted |
| stat_valid | output | 1 | Status offered to the channel |
| stat_dev | output | DEV_W | Device of the offered status |
| stat_byte | output | 8 | Offered status byte |

## Verification
The bench builds the block with DEV_W = 2, which gives four devices. With four devices a single run can hold status pending for one device while it selects another. It can also post to a low and a high device at once, so the lowest-index offer order and the untouched status of a third device can both be observed. Every command class goes through its full sequence to completion, and the two-step ending of a data command is acknowledged step by step.

// File: rtl/csr_pkg.sv
package csr_pkg;
  localparam int ST_SM   = 6;
  localparam int ST_BUSY = 4;
  localparam int ST_CE   = 3;
  localparam int ST_DE   = 2;
  localparam int ST_UC   = 1;

  typedef enum logic [2:0] {
    CLS_TIO, CLS_NOP, CLS_IMM, CLS_SEP, CLS_TOG, CLS_BAD
  } cmd_cls_t;
endpackage

// File: rtl/csr_decode.sv
module csr_decode
  import csr_pkg::*;
(
  input  logic [7:0] cmd,
  output cmd_cls_t   cls
);
  always_comb begin
    unique case (cmd)
      8'h00:                          cls = CLS_TIO;
      8'h03:                          cls = CLS_NOP;
      8'h0B, 8'h0F, 8'h1B:            cls = CLS_IMM;
      8'h01, 8'h02, 8'h05, 8'h06,
      8'h0D:                          cls = CLS_SEP;
      8'h04, 8'h0A, 8'h12, 8'hE4:     cls = CLS_TOG;
      default:                        cls = CLS_BAD;
    endcase
  end
endmodule

// File: rtl/csr_pend.sv
module csr_pend
  import csr_pkg::*;
#(
  parameter int NUM_DEV = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_DEV-1:0]        clr_mask,
  input  logic [NUM_DEV-1:0][7:0]   or_bits,
  input  logic [NUM_DEV-1:0]        follow_set,
  output logic [NUM_DEV-1:0][7:0]   pend
);
  localparam logic [7:0] DE_BYTE = 8'(1 << ST_DE);

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
    logic [7:0] pend_d;
    logic       follow_q, follow_d;

    always_comb begin
      pend_d   = clr_mask[i] ? (follow_q ? DE_BYTE : 8'h00) : pend[i];
      pend_d   = pend_d | or_bits[i];
      follow_d = (follow_q & ~clr_mask[i]) | follow_set[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[i]  <= 8'h00;
        follow_q <= 1'b0;
      end else begin
        pend[i]  <= pend_d;
        follow_q <= follow_d;
      end
    end

    // R12
    clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask[i] && !follow_q && or_bits[i] == 8'h00) |=> pend[i] == 8'h00);
    // R10
    follow_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask[i] && follow_q) |=> pend[i][ST_DE]);
  end
endmodule

// File: rtl/csr_present.sv
module csr_present #(
  parameter int NUM_DEV = 4,
  parameter int DEV_W   = 2
) (
  input  logic [NUM_DEV-1:0][7:0] pend,
  output logic                    any,
  output logic [DEV_W-1:0]        idx,
  output logic [7:0]              sbyte
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NUM_DEV - 1; i >= 0; i--) begin
      if (pend[i] != 8'h00) begin
        any = 1'b1;
        idx = DEV_W'(i);
      end
    end
    sbyte = pend[idx];
  end
endmodule

// File: rtl/chan_status_resp.sv
module chan_status_resp
  import csr_pkg::*;
#(
  parameter int DEV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_valid,
  input  logic [DEV_W-1:0] sel_dev,
  input  logic [7:0]       sel_cmd,
  input  logic             sel_perr,
  input  logic             sel_intv,
  input  logic             rst_busy,
  input  logic             done_valid,
  input  logic             post_valid,
  input  logic [DEV_W-1:0] post_dev,
  input  logic [7:0]       post_bits,
  input  logic             stat_ack,
  output logic             rsp_valid,
  output logic [7:0]       rsp_status,
  output logic             rsp_accept,
  output logic             stat_valid,
  output logic [DEV_W-1:0] stat_dev,
  output logic [7:0]       stat_byte
);
  localparam int         NUM_DEV = 1 << DEV_W;
  localparam logic [7:0] B_BUSY  = 8'(1 << ST_BUSY);
  localparam logic [7:0] B_CUB   = 8'((1 << ST_BUSY) | (1 << ST_SM));
  localparam logic [7:0] B_CE    = 8'(1 << ST_CE);
  localparam logic [7:0] B_DE    = 8'(1 << ST_DE);
  localparam logic [7:0] B_UC    = 8'(1 << ST_UC);

  cmd_cls_t                  cls;
  logic [NUM_DEV-1:0][7:0]   pend;
  logic [NUM_DEV-1:0]        clr_mask, follow_set;
  logic [NUM_DEV-1:0][7:0]   or_bits;

  logic             rsp_valid_d, rsp_accept_d;
  logic [7:0]       rsp_status_d;
  logic             op_busy_q, op_busy_d;
  logic [DEV_W-1:0] op_dev_q, op_dev_d;
  cmd_cls_t         op_cls_q, op_cls_d;
  logic             start_op, tio_clr, other_pend;
  logic [7:0]       addr_pend;

  csr_decode u_dec (.cmd(sel_cmd), .cls(cls));

  csr_pend #(.NUM_DEV(NUM_DEV)) u_pend (
    .clk(clk), .rst_n(rst_n), .clr_mask(clr_mask), .or_bits(or_bits),
    .follow_set(follow_set), .pend(pend));

  csr_present #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) u_pres (
    .pend(pend), .any(stat_valid), .idx(stat_dev), .sbyte(stat_byte));

  // selection reply decision
  always_comb begin
    addr_pend  = pend[sel_dev];
    other_pend = 1'b0;
    for (int i = 0; i < NUM_DEV; i++)
      if (DEV_W'(i) != sel_dev && pend[i] != 8'h00) other_pend = 1'b1;

    rsp_status_d = 8'h00;
    rsp_accept_d = 1'b0;
    start_op     = 1'b0;
    tio_clr      = 1'b0;
    if (rst_busy) begin
      rsp_status_d = B_CUB;
    end else if (addr_pend != 8'h00) begin
      if (cls == CLS_TIO) begin
        rsp_status_d = addr_pend;
        rsp_accept_d = 1'b1;
        tio_clr      = 1'b1;
      end else begin
        rsp_status_d = addr_pend | B_BUSY;
      end
    end else if (cls == CLS_TIO) begin
      rsp_accept_d = 1'b1;
    end else if (op_busy_q) begin
      rsp_status_d = (op_dev_q == sel_dev) ? B_BUSY : B_CUB;
    end else if (other_pend) begin
      rsp_status_d = B_CUB;
    end else if (sel_perr || sel_intv || cls == CLS_BAD) begin
      rsp_status_d = B_UC;
    end else begin
      rsp_accept_d = 1'b1;
      unique case (cls)
        CLS_NOP: rsp_status_d = B_CE | B_DE;
        CLS_IMM: begin rsp_status_d = B_CE; start_op = 1'b1; end
        default: start_op = 1'b1;
      endcase
    end
    rsp_valid_d = sel_valid;
    if (!sel_valid) begin
      start_op = 1'b0;
      tio_clr  = 1'b0;
    end
  end

  // pending-status update requests and operation tracking
  always_comb begin
    clr_mask   = '0;
    follow_set = '0;
    or_bits    = '0;
    if (tio_clr) clr_mask[sel_dev] = 1'b1;
    if (stat_ack && stat_valid) clr_mask[stat_dev] = 1'b1;
    if (post_valid) or_bits[post_dev] = post_bits;
    op_busy_d = op_busy_q;
    op_dev_d  = op_dev_q;
    op_cls_d  = op_cls_q;
    if (done_valid && op_busy_q) begin
      op_busy_d = 1'b0;
      unique case (op_cls_q)
        CLS_IMM: or_bits[op_dev_q] = or_bits[op_dev_q] | B_DE;
        CLS_SEP: begin
          or_bits[op_dev_q]    = or_bits[op_dev_q] | B_CE;
          follow_set[op_dev_q] = 1'b1;
        end
        default: or_bits[op_dev_q] = or_bits[op_dev_q] | B_CE | B_DE;
      endcase
    end
    if (start_op) begin
      op_busy_d = 1'b1;
      op_dev_d  = sel_dev;
      op_cls_d  = cls;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_status <= 8'h00;
      rsp_accept <= 1'b0;
      op_busy_q  <= 1'b0;
      op_dev_q   <= '0;
      op_cls_q   <= CLS_NOP;
    end else begin
      rsp_valid  <= rsp_valid_d;
      if (sel_valid) begin
        rsp_status <= rsp_status_d;
        rsp_accept <= rsp_accept_d;
      end
      op_busy_q  <= op_busy_d;
      op_dev_q   <= op_dev_d;
      op_cls_q   <= op_cls_d;
    end
  end

  // R1
  reply_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |=> rsp_valid);
  // R1
  reply_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(sel_valid));
  // R5
  uc_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == B_UC) |-> !rsp_accept);
  // R9
  busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status[ST_BUSY]) |-> !rsp_accept);
  // R12
  offer_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> stat_byte != 8'h00);
  // R11
  reset_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && rst_busy) |=> (rsp_status == B_CUB && !rsp_accept));
endmodule

// File: tb/chan_status_resp_test.sv
module chan_status_resp_test;
  localparam int DEV_W = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic sel_valid, sel_perr, sel_intv, rst_busy, done_valid, post_valid, stat_ack;
  logic [DEV_W-1:0] sel_dev, post_dev, stat_dev;
  logic [7:0] sel_cmd, post_bits, rsp_status, stat_byte;
  logic rsp_valid, rsp_accept, stat_valid;

  int n_chk = 0;
  int n_bad = 0;

  always #5ns clk = ~clk;

  chan_status_resp #(.DEV_W(DEV_W)) uut (
    .clk(clk), .rst_n(rst_n), .sel_valid(sel_valid), .sel_dev(sel_dev),
    .sel_cmd(sel_cmd), .sel_perr(sel_perr), .sel_intv(sel_intv),
    .rst_busy(rst_busy), .done_valid(done_valid), .post_valid(post_valid),
    .post_dev(post_dev), .post_bits(post_bits), .stat_ack(stat_ack),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_accept(rsp_accept),
    .stat_valid(stat_valid), .stat_dev(stat_dev), .stat_byte(stat_byte));

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic select(input int dev, input int cmd, input bit perr, input bit intv,
                        input string req, input int exp_st, input bit exp_acc);
    @(negedge clk);
    sel_valid = 1'b1; sel_dev = DEV_W'(dev); sel_cmd = 8'(cmd);
    sel_perr = perr; sel_intv = intv;
    @(negedge clk);
    sel_valid = 1'b0; sel_perr = 1'b0; sel_intv = 1'b0;
    check({req, " valid"}, int'(rsp_valid), 1);
    check({req, " status"}, int'(rsp_status), exp_st);
    check({req, " accept"}, int'(rsp_accept), int'(exp_acc));
    @(negedge clk);
    check({req, " one-cycle"}, int'(rsp_valid), 0);
  endtask

  task automatic offer(input string req, input bit v, input int dev, input int b);
    check({req, " offer valid"}, int'(stat_valid), int'(v));
    if (v) begin
      check({req, " offer dev"}, int'(stat_dev), dev);
      check({req, " offer byte"}, int'(stat_byte), b);
    end
  endtask

  task automatic pulse_done();
    @(negedge clk); done_valid = 1'b1;
    @(negedge clk); done_valid = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); stat_ack = 1'b1;
    @(negedge clk); stat_ack = 1'b0;
  endtask

  task automatic post(input int dev, input int bits);
    @(negedge clk); post_valid = 1'b1; post_dev = DEV_W'(dev); post_bits = 8'(bits);
    @(negedge clk); post_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset rsp_valid", int'(rsp_valid), 0);
    offer("R1 reset", 1'b0, 0, 0);
  endtask

  task automatic t_noop();
    select(0, 8'h03, 0, 0, "R4 noop", 8'h0C, 1'b1);
    select(1, 8'h03, 0, 0, "R4 no op in flight", 8'h0C, 1'b1);
    offer("R4 nothing queued", 1'b0, 0, 0);
  endtask

  task automatic t_unit_check();
    select(1, 8'h77, 0, 0, "R5 bad code", 8'h02, 1'b0);
    select(1, 8'h01, 1, 0, "R5 parity", 8'h02, 1'b0);
    select(2, 8'h04, 0, 1, "R5 intervention", 8'h02, 1'b0);
  endtask

  task automatic t_immediate();
    select(2, 8'h0B, 0, 0, "R3 immediate", 8'h08, 1'b1);
    select(2, 8'h03, 0, 0, "R9 same device", 8'h10, 1'b0);
    select(1, 8'h03, 0, 0, "R9 other device", 8'h50, 1'b0);
    offer("R3 before done", 1'b0, 0, 0);
    pulse_done();
    offer("R3 device end", 1'b1, 2, 8'h04);
    pulse_ack();
    offer("R12 cleared on ack", 1'b0, 0, 0);
  endtask

  task automatic t_separate();
    select(1, 8'h01, 0, 0, "R2 data cmd", 8'h00, 1'b1);
    pulse_done();
    offer("R10 channel end first", 1'b1, 1, 8'h08);
    pulse_ack();
    offer("R10 device end after ack", 1'b1, 1, 8'h04);
    pulse_ack();
    offer("R10 all taken", 1'b0, 0, 0);
  endtask

  task automatic t_together();
    select(3, 8'hE4, 0, 0, "R2 completion cmd", 8'h00, 1'b1);
    pulse_done();
    offer("R10 together", 1'b1, 3, 8'h0C);
    pulse_ack();
    offer("R10 together taken", 1'b0, 0, 0);
  endtask

  task automatic t_pending();
    post(2, 8'h80);
    offer("R12 posted", 1'b1, 2, 8'h80);
    select(2, 8'h02, 0, 0, "R6 own pending", 8'h90, 1'b0);
    offer("R6 pending kept", 1'b1, 2, 8'h80);
    select(1, 8'h03, 0, 0, "R8 other pending", 8'h50, 1'b0);
    select(1, 8'h00, 0, 0, "R7 test io empty", 8'h00, 1'b1);
    select(2, 8'h00, 0, 0, "R7 test io pending", 8'h80, 1'b1);
    offer("R7 cleared", 1'b0, 0, 0);
    post(3, 8'h01);
    post(0, 8'h80);
    offer("R12 lowest first", 1'b1, 0, 8'h80);
    select(3, 8'h00, 0, 0, "R7 test io dev3", 8'h01, 1'b1);
    offer("R7 dev0 untouched", 1'b1, 0, 8'h80);
    pulse_ack();
    offer("R12 all taken", 1'b0, 0, 0);
  endtask

  task automatic t_rst_busy();
    @(negedge clk); rst_busy = 1'b1;
    select(0, 8'h03, 0, 0, "R11 reset busy", 8'h50, 1'b0);
    @(negedge clk); rst_busy = 1'b0;
    select(0, 8'h06, 0, 0, "R2 after reset busy", 8'h00, 1'b1);
    pulse_done();
    pulse_ack();
    pulse_ack();
    offer("R10 drained", 1'b0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sel_valid = 1'b0; sel_dev = '0; sel_cmd = 8'h00;
    sel_perr = 1'b0; sel_intv = 1'b0; rst_busy = 1'b0; done_valid = 1'b0;
    post_valid = 1'b0; post_dev = '0; post_bits = 8'h00; stat_ack = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_noop();
    t_unit_check();
    t_immediate();
    t_separate();
    t_together();
    t_pending();
    t_rst_busy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule